// File: doc/BRIEF.md
# Scanline Vertical Counter with Repeat Jump

This block keeps the vertical line position of a video timing generator. A line strobe from the horizontal timing logic advances it by one line. The CPU reads the 8-bit count value. A frame is longer than 256 lines, so the count cannot simply run up and wrap. On every other visit to 0xDA, the next value is 0xD5 instead of 0xDB. This replays six values and gives a frame of 262 strobes. A single phase bit records which visit is the current one.

The block also decodes the active display window from the current count. It raises a sticky frame interrupt flag on the strobe that ends the last active line. The flag stays set until a clear pulse arrives, for example from a status read. Masking the flag, horizontal timing and drawing are handled elsewhere.

Top module: `vline_counter`

## Requirements
- R1: While reset is high at a clock edge, the count goes to 0x00, the phase bit goes to 0 and the interrupt flag goes to 0, all visible after that edge.
- R2: Each clock edge with the line strobe high adds one to the count, except in the 0xDA case. Without a strobe, the count holds its value.
- R3: On a strobe at count 0xDA, the phase bit inverts. If it is now 1, the next count is 0xD5. The first 0xDA visit after reset is therefore followed by 0xD5.
- R4: On a strobe at 0xDA where the inverted phase bit is 0, the count goes to 0xDB. This is every second visit.
- R5: A strobe at 0xFF gives 0x00.
- R6: The active-line output is high exactly when the count lies in 0x18 to 0xA7 inclusive. It follows the count with no extra delay.
- R7: The strobe that moves the count from 0xA7 to 0xA8 sets the interrupt flag. The flag is visible from the same edge at which the count shows 0xA8.
- R8: A set flag stays set until a clock edge with the clear input high. It reads 0 after that edge. A clear while the flag is already 0 has no effect.
- R9: When a setting strobe and a clear arrive at the same edge, the flag ends up set.
- R10: From reset, the count reaches 0x00 again after exactly 262 strobes, and again 262 strobes after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle strobe per scanline |
| irq_clear | input | 1 | One-cycle clear pulse for the frame flag |
| vcount | output | 8 | Current vertical count value |
| active_line | output | 1 | Current line is inside the active display window |
| frame_irq | output | 1 | Sticky flag set at the end of the active area |

## Verification
The count and the interrupt flag are registers. Both change at the clock edge where the strobe or clear is sampled, and they are due one edge after the input is driven. The active-line output is decoded from the registered count, so it changes at that same edge and not one later.

The bench drives inputs on the falling edge and advances its own model at the following rising edge. It compares all three outputs on the next falling edge. Each result is therefore checked in the cycle it is due, with no slack. Directed checks on the 0xDA visits, the wrap and the frame length use the values already observed at those falling edges.

// File: rtl/vline_pkg.sv
package vline_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] vcnt_t;

    localparam vcnt_t DEF_JUMP_FROM = 8'hDA;
    localparam vcnt_t DEF_JUMP_TO   = 8'hD5;
    localparam vcnt_t DEF_ACT_FIRST = 8'h18;
    localparam vcnt_t DEF_ACT_LAST  = 8'hA7;

    typedef struct packed {
        vcnt_t count;
        logic  rewound;
    } vstate_t;

    localparam vstate_t VSTATE_RESET = '{count: '0, rewound: 1'b0};

    function automatic vstate_t vline_advance(vstate_t s, vcnt_t jump_from, vcnt_t jump_to);
        vstate_t n;
        n = s;
        if (s.count == jump_from) begin
            n.rewound = ~s.rewound;
            n.count   = n.rewound ? jump_to : s.count + vcnt_t'(1);
        end else begin
            n.count   = s.count + vcnt_t'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/vline_seq.sv
module vline_seq
    import vline_pkg::*;
#(
    parameter vcnt_t JUMP_FROM = DEF_JUMP_FROM,
    parameter vcnt_t JUMP_TO   = DEF_JUMP_TO
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_tick,
    output vcnt_t count
);

    vstate_t st_q;
    vstate_t st_d;

    always_comb begin
        st_d = st_q;
        if (line_tick) st_d = vline_advance(st_q, JUMP_FROM, JUMP_TO);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= VSTATE_RESET;
        else     st_q <= st_d;
    end

    assign count = st_q.count;

    // R1
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (st_q.count == '0 && !st_q.rewound));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !line_tick |=> $stable(st_q.count));

    assert_first_pass_jump_R3: assert property (@(posedge clk) disable iff (rst)
        (line_tick && st_q.count == JUMP_FROM && !st_q.rewound) |=> (st_q.count == JUMP_TO));

    assert_second_pass_on_R4: assert property (@(posedge clk) disable iff (rst)
        (line_tick && st_q.count == JUMP_FROM && st_q.rewound)
            |=> (st_q.count == JUMP_FROM + vcnt_t'(1)));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (line_tick && st_q.count == '1) |=> (st_q.count == '0));

endmodule

// File: rtl/vline_window.sv
module vline_window
    import vline_pkg::*;
#(
    parameter vcnt_t ACT_FIRST = DEF_ACT_FIRST,
    parameter vcnt_t ACT_LAST  = DEF_ACT_LAST
) (
    input  vcnt_t count,
    output logic  active
);

    logic above_first;
    logic below_last;

    generate
        if (ACT_FIRST == '0) begin : g_no_low
            assign above_first = 1'b1;
        end else begin : g_low
            assign above_first = (count >= ACT_FIRST);
        end
        if (ACT_LAST == '1) begin : g_no_high
            assign below_last = 1'b1;
        end else begin : g_high
            assign below_last = (count <= ACT_LAST);
        end
    endgenerate

    assign active = above_first && below_last;

    // R6
    always_comb begin
        assert_window_edges_R6: assert (!(count == ACT_LAST + vcnt_t'(1)) || !active);
    end

endmodule

// File: rtl/vline_irq.sv
module vline_irq
    import vline_pkg::*;
#(
    parameter vcnt_t ACT_LAST = DEF_ACT_LAST
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  line_tick,
    input  vcnt_t count,
    input  logic  clear,
    output logic  irq
);

    logic set_evt;
    logic irq_q;

    assign set_evt = line_tick && (count == ACT_LAST);

    always_ff @(posedge clk) begin
        if (rst)          irq_q <= 1'b0;
        else if (set_evt) irq_q <= 1'b1;
        else if (clear)   irq_q <= 1'b0;
    end

    assign irq = irq_q;

    assert_set_on_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (line_tick && count == ACT_LAST) |=> irq_q);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clear) |=> irq_q);

    assert_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (clear && !(line_tick && count == ACT_LAST)) |=> !irq_q);

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clear && line_tick && count == ACT_LAST) |=> irq_q);

endmodule

// File: rtl/vline_counter.sv
module vline_counter
    import vline_pkg::*;
#(
    parameter vcnt_t JUMP_FROM = DEF_JUMP_FROM,
    parameter vcnt_t JUMP_TO   = DEF_JUMP_TO,
    parameter vcnt_t ACT_FIRST = DEF_ACT_FIRST,
    parameter vcnt_t ACT_LAST  = DEF_ACT_LAST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_tick,
    input  logic             irq_clear,
    output logic [CNT_W-1:0] vcount,
    output logic             active_line,
    output logic             frame_irq
);

    vcnt_t count;

    vline_seq #(.JUMP_FROM(JUMP_FROM), .JUMP_TO(JUMP_TO)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .count     (count)
    );

    vline_window #(.ACT_FIRST(ACT_FIRST), .ACT_LAST(ACT_LAST)) u_win (
        .count  (count),
        .active (active_line)
    );

    vline_irq #(.ACT_LAST(ACT_LAST)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .count     (count),
        .clear     (irq_clear),
        .irq       (frame_irq)
    );

    assign vcount = count;

    assert_irq_with_a8_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_irq) |-> (vcount == ACT_LAST + vcnt_t'(1)));

endmodule

// File: tb/vline_counter_test.sv
module vline_counter_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_tick = 1'b0;
    logic       irq_clear = 1'b0;
    logic [7:0] vcount;
    logic       active_line;
    logic       frame_irq;

    int checks = 0;
    int failures = 0;
    int m_cnt = 0;
    int m_rew = 0;
    int m_irq = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vline_counter uut (
        .clk         (clk),
        .rst         (rst),
        .line_tick   (line_tick),
        .irq_clear   (irq_clear),
        .vcount      (vcount),
        .active_line (active_line),
        .frame_irq   (frame_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        int exp_act;
        exp_act = (m_cnt >= 24 && m_cnt <= 167) ? 1 : 0;
        check(vcount == m_cnt, "R2 count", vcount, m_cnt);
        check(active_line == exp_act, "R6 active", active_line, exp_act);
        check(frame_irq == m_irq, "R8 irq", frame_irq, m_irq);
    endtask

    task automatic cyc(input bit t, input bit c);
        line_tick = t;
        irq_clear = c;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_rew = 0; m_irq = 0;
        end else begin
            if (t && m_cnt == 167) m_irq = 1;
            else if (c) m_irq = 0;
            if (t) begin
                if (m_cnt == 218) begin
                    m_rew = 1 - m_rew;
                    m_cnt = (m_rew == 1) ? 213 : 219;
                end else begin
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int da_visits = 0;
        int ticks_since = 0;
        int zeros = 0;
        int prev;
        @(negedge clk);
        cyc(0, 0);
        cyc(0, 0);
        // R1 reset state
        check(vcount == 0 && frame_irq == 0 && active_line == 0, "R1 reset", vcount, 0);
        rst = 1'b0;
        cyc(0, 1);
        // R8 clear with no flag pending leaves it low
        check(frame_irq == 0, "R8 idle clear", frame_irq, 0);
        cyc(0, 0);
        for (int i = 0; i < 560; i++) begin
            bit c;
            prev = vcount;
            c = 1'b0;
            // frame 2: clear coincides with the setting strobe (R9)
            if (zeros == 1 && prev == 8'hA7) c = 1'b1;
            // frame 1: clear some lines after the flag is set
            if (zeros == 0 && prev == 8'hB0) c = 1'b1;
            cyc(1, c);
            ticks_since++;
            if (prev == 8'hA7) check(frame_irq == 1, "R7 set at A8", frame_irq, 1);
            if (prev == 8'hA7 && c) check(frame_irq == 1, "R9 set wins", frame_irq, 1);
            if (prev == 8'hB0 && c) check(frame_irq == 0, "R8 cleared", frame_irq, 0);
            if (prev == 8'hDA) begin
                da_visits++;
                if (da_visits % 2 == 1) check(vcount == 8'hD5, "R3 jump", vcount, 8'hD5);
                else                    check(vcount == 8'hDB, "R4 pass", vcount, 8'hDB);
            end
            if (prev == 8'h17) check(active_line == 1, "R6 first", active_line, 1);
            if (prev == 8'hA7) check(active_line == 0, "R6 past last", active_line, 0);
            if (prev == 8'hFF) begin
                check(vcount == 0, "R5 wrap", vcount, 0);
                check(ticks_since == 262, "R10 frame length", ticks_since, 262);
                ticks_since = 0;
                zeros++;
            end
            if (i % 7 == 3) begin
                cyc(0, 0);
                check(vcount == prev + 1 || prev == 8'hDA || prev == 8'hFF,
                      "R2 hold", vcount, prev + 1);
            end
        end
        check(zeros == 2, "R10 frames seen", zeros, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule